// File: doc/BRIEF.md
# Sprite Slot Upload Port Controller

This block sits between the CPU's I/O bus and the storage of a hardware sprite engine. It watches three I/O ports: a 16-bit-decoded select/status port, a sprite-attribute data port and a pattern-data port. The latter two are decoded on the low address byte only. A write to the select port picks one sprite slot and one pattern slot at once. After that, the two data ports each walk their own write index forward without affecting the other. The block turns each data-port write into a same-cycle write strobe, address and data for an attribute RAM (64 sprites) or a pattern RAM (64 slots of 256 bytes).

Attribute records are 4 or 5 bytes long. The fourth byte of a record says whether a fifth follows, and the sprite index moves to the next slot once a record is complete. Pattern bytes fill a slot left to right and top to bottom. Bit 7 of the select value can start the upload halfway into the slot, at byte 128.

The block also holds two sticky status flags that the renderer sets: sprite collision, and "too many sprites on a line". Reading the status port returns both flags and clears them. A set request that arrives in the same cycle as the clear wins.

Top module: `sprite_port_frontend`

## Requirements
- R1: A write to the full 16-bit address 0x303B loads the sprite slot and the pattern slot from data bits 5:0. It also resets the attribute byte counter to 0, and it raises neither RAM write strobe.
- R2: If data bit 7 of a select write is 1, the pattern index becomes slot*256+128. If it is 0, the pattern index becomes slot*256.
- R3: A write whose low address byte is 0x5B raises pat_we in the same cycle, with pat_addr equal to the pattern index and pat_wdata equal to the written byte. The index then grows by one and wraps from 16383 to 0, so it crosses slot boundaries.
- R4: A write whose low address byte is 0x57 raises attr_we in the same cycle, with attr_addr = slot*8 + byte counter and attr_wdata equal to the written byte.
- R5: A record ends after byte 3 if bit 6 of that byte is 0, and after byte 4 otherwise. At the end of a record the byte counter returns to 0 and the sprite slot grows by one, wrapping from 63 to 0.
- R6: Attribute writes leave the pattern index unchanged, and pattern writes leave the sprite slot and byte counter unchanged.
- R7: A read of address 0x303B drives io_rdata with bit 0 = collision flag, bit 1 = max-sprites flag and all other bits 0. Any other read returns 0.
- R8: A status read clears both flags from the next cycle on.
- R9: A flag set by ren_collide_set or ren_maxspr_set stays set until a status read. A set in the same cycle as a status read leaves that flag set.
- R10: The select/status port needs all 16 address bits to match. For example, a write to 0x313B has no effect, and reads of 0x303A or 0x313B return 0 and clear nothing. Attribute and pattern writes match for any high address byte.
- R11: After reset both flags are 0, both slots, the pattern index and the byte counter are 0, and no RAM strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | Status read data, 0 when not a status read |
| ren_collide_set | input | 1 | Renderer: collision seen |
| ren_maxspr_set | input | 1 | Renderer: line ran out of time |
| attr_we | output | 1 | Attribute RAM write enable |
| attr_addr | output | 9 | Attribute RAM address {slot, byte} |
| attr_wdata | output | 8 | Attribute RAM write data |
| pat_we | output | 1 | Pattern RAM write enable |
| pat_addr | output | 14 | Pattern RAM byte address |
| pat_wdata | output | 8 | Pattern RAM write data |

## Verification
The bench builds the block with its default parameters: 6-bit slots, 256-byte pattern slots and 4/5-byte records. It sweeps every slot with both pattern start offsets, alternating short and long records. This reaches the slot wrap from 63 to 0, and 128 further writes reach the wrap of the 14-bit pattern index. Flag tests cover single sets, double sets, set-versus-clear collisions and reads at addresses that differ from the status port only in one address byte.

// File: rtl/sprite_port_pkg.sv
package sprite_port_pkg;
   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_SEL  = 2'd1,
      HIT_ATTR = 2'd2,
      HIT_PAT  = 2'd3
   } port_hit_e;

   localparam int FLAG_COLLIDE = 0;
   localparam int FLAG_MAXSPR  = 1;
   localparam int NUM_FLAGS    = 2;
endpackage

// File: rtl/spr_port_decode.sv
module spr_port_decode
   import sprite_port_pkg::*;
#(
   parameter logic [15:0] SEL_ADDR = 16'h303B,
   parameter logic [7:0]  ATTR_LO  = 8'h57,
   parameter logic [7:0]  PAT_LO   = 8'h5B
) (
   input  logic [15:0] addr,
   input  logic        wr,
   input  logic        rd,
   output logic        sel_wr,
   output logic        stat_rd,
   output logic        attr_wr,
   output logic        pat_wr
);
   port_hit_e hit;

   generate
      if (ATTR_LO == PAT_LO) begin : g_bad_lo
         $error("attribute and pattern ports share a low byte");
      end
      if (SEL_ADDR[7:0] == ATTR_LO || SEL_ADDR[7:0] == PAT_LO) begin : g_bad_sel
         $error("select port low byte collides with a data port");
      end
   endgenerate

   always_comb begin
      hit = HIT_NONE;
      if (addr == SEL_ADDR)          hit = HIT_SEL;
      else if (addr[7:0] == ATTR_LO) hit = HIT_ATTR;
      else if (addr[7:0] == PAT_LO)  hit = HIT_PAT;
   end

   assign sel_wr  = wr && (hit == HIT_SEL);
   assign stat_rd = rd && (hit == HIT_SEL);
   assign attr_wr = wr && (hit == HIT_ATTR);
   assign pat_wr  = wr && (hit == HIT_PAT);
endmodule

// File: rtl/spr_attr_index.sv
module spr_attr_index #(
   parameter int SLOT_W    = 6,
   parameter int SHORT_LEN = 4,
   parameter int LONG_LEN  = 5,
   localparam int IDX_W    = $clog2(LONG_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_wr,
   input  logic [SLOT_W-1:0] sel_slot,
   input  logic              attr_wr,
   input  logic              ext_flag,
   output logic [SLOT_W-1:0] slot,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_LEN - 1);
   localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_LEN - 1);

   generate
      if (SHORT_LEN < 1 || LONG_LEN <= SHORT_LEN) begin : g_bad_len
         $error("record lengths must satisfy 1 <= short < long");
      end
   endgenerate

   logic rec_last;

   always_comb begin
      rec_last = (idx == LONG_LAST) || ((idx == SHORT_LAST) && !ext_flag);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot <= '0;
         idx  <= '0;
      end else if (sel_wr) begin
         slot <= sel_slot;
         idx  <= '0;
      end else if (attr_wr) begin
         if (rec_last) begin
            idx  <= '0;
            slot <= slot + 1'b1;
         end else begin
            idx  <= idx + 1'b1;
         end
      end
   end

   a_r5_idx_bound : assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LONG_LAST);

   a_r1_select_load : assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (slot == $past(sel_slot)) && (idx == '0));

   a_r5_long_ends : assert property (@(posedge clk) disable iff (!rst_n)
      (attr_wr && !sel_wr && idx == LONG_LAST) |=>
         (idx == '0) && (slot == SLOT_W'($past(slot) + 1'b1)));

   a_r6_attr_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!attr_wr && !sel_wr) |=> $stable(slot) && $stable(idx));
endmodule

// File: rtl/spr_pattern_index.sv
module spr_pattern_index #(
   parameter int SLOT_W = 6,
   parameter int BYTE_W = 8,
   localparam int PTR_W = SLOT_W + BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_wr,
   input  logic [SLOT_W-1:0] sel_slot,
   input  logic              sel_half,
   input  logic              pat_wr,
   output logic [PTR_W-1:0]  ptr
);
   localparam int LOW_W = BYTE_W - 1;

   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("pattern slot must hold at least 4 bytes");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (sel_wr) begin
         ptr <= {sel_slot, sel_half, {LOW_W{1'b0}}};
      end else if (pat_wr) begin
         ptr <= ptr + 1'b1;
      end
   end

   a_r2_start_point : assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> ptr == {$past(sel_slot), $past(sel_half), {LOW_W{1'b0}}});

   a_r3_ptr_step : assert property (@(posedge clk) disable iff (!rst_n)
      (pat_wr && !sel_wr) |=> ptr == PTR_W'($past(ptr) + 1'b1));

   a_r6_pat_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!pat_wr && !sel_wr) |=> $stable(ptr));
endmodule

// File: rtl/spr_status_flags.sv
module spr_status_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr)    q[i] <= 1'b0;
         end

         a_r9_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);

         a_r8_clear_takes : assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !set[i]) |=> !q[i]);

         a_r9_sticky : assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !clr) |=> q[i]);
      end
   endgenerate
endmodule

// File: rtl/sprite_port_frontend.sv
module sprite_port_frontend
   import sprite_port_pkg::*;
#(
   parameter int          SLOT_W     = 6,
   parameter int          PAT_BYTE_W = 8,
   parameter int          DATA_W     = 8,
   parameter int          REC_SHORT  = 4,
   parameter int          REC_LONG   = 5,
   parameter int          EXT_BIT    = 6,
   parameter bit          HALF_START = 1'b1,
   parameter logic [15:0] SEL_ADDR   = 16'h303B,
   parameter logic [7:0]  ATTR_LO    = 8'h57,
   parameter logic [7:0]  PAT_LO     = 8'h5B,
   localparam int ATTR_AW = SLOT_W + $clog2(REC_LONG),
   localparam int PAT_AW  = SLOT_W + PAT_BYTE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [15:0]        io_addr,
   input  logic [DATA_W-1:0]  io_wdata,
   input  logic               io_wr,
   input  logic               io_rd,
   output logic [DATA_W-1:0]  io_rdata,
   input  logic               ren_collide_set,
   input  logic               ren_maxspr_set,
   output logic               attr_we,
   output logic [ATTR_AW-1:0] attr_addr,
   output logic [DATA_W-1:0]  attr_wdata,
   output logic               pat_we,
   output logic [PAT_AW-1:0]  pat_addr,
   output logic [DATA_W-1:0]  pat_wdata
);
   localparam int IDX_W = $clog2(REC_LONG);

   generate
      if (SLOT_W + 1 > DATA_W) begin : g_bad_slot
         $error("slot field plus half flag exceed data width");
      end
      if (EXT_BIT >= DATA_W) begin : g_bad_ext
         $error("record extension bit outside data word");
      end
      if (NUM_FLAGS > DATA_W) begin : g_bad_flags
         $error("status flags exceed data width");
      end
   endgenerate

   logic              sel_wr, stat_rd, attr_wr, pat_wr;
   logic              sel_half;
   logic [SLOT_W-1:0] sel_slot;
   logic [SLOT_W-1:0] a_slot;
   logic [IDX_W-1:0]  a_idx;
   logic [PAT_AW-1:0] p_ptr;
   logic [NUM_FLAGS-1:0] flag_set, flags;

   spr_port_decode #(
      .SEL_ADDR (SEL_ADDR),
      .ATTR_LO  (ATTR_LO),
      .PAT_LO   (PAT_LO)
   ) u_decode (
      .addr    (io_addr),
      .wr      (io_wr),
      .rd      (io_rd),
      .sel_wr  (sel_wr),
      .stat_rd (stat_rd),
      .attr_wr (attr_wr),
      .pat_wr  (pat_wr)
   );

   assign sel_slot = io_wdata[SLOT_W-1:0];

   generate
      if (HALF_START) begin : g_half_on
         assign sel_half = io_wdata[DATA_W-1];
      end else begin : g_half_off
         assign sel_half = 1'b0;
      end
   endgenerate

   spr_attr_index #(
      .SLOT_W    (SLOT_W),
      .SHORT_LEN (REC_SHORT),
      .LONG_LEN  (REC_LONG)
   ) u_attr (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_wr   (sel_wr),
      .sel_slot (sel_slot),
      .attr_wr  (attr_wr),
      .ext_flag (io_wdata[EXT_BIT]),
      .slot     (a_slot),
      .idx      (a_idx)
   );

   spr_pattern_index #(
      .SLOT_W (SLOT_W),
      .BYTE_W (PAT_BYTE_W)
   ) u_pat (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_wr   (sel_wr),
      .sel_slot (sel_slot),
      .sel_half (sel_half),
      .pat_wr   (pat_wr),
      .ptr      (p_ptr)
   );

   always_comb begin
      flag_set = '0;
      flag_set[FLAG_COLLIDE] = ren_collide_set;
      flag_set[FLAG_MAXSPR]  = ren_maxspr_set;
   end

   spr_status_flags #(
      .N (NUM_FLAGS)
   ) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (stat_rd),
      .q     (flags)
   );

   assign attr_we    = attr_wr;
   assign attr_addr  = {a_slot, a_idx};
   assign attr_wdata = io_wdata;
   assign pat_we     = pat_wr;
   assign pat_addr   = p_ptr;
   assign pat_wdata  = io_wdata;

   always_comb begin
      io_rdata = '0;
      if (stat_rd) io_rdata[NUM_FLAGS-1:0] = flags;
   end

   a_r10_one_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({attr_we, pat_we}));

   a_r7_quiet_bus : assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> io_rdata == '0);
endmodule

// File: tb/test_sprite_port_frontend.sv
`timescale 1ns/1ps
module test_sprite_port_frontend;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic        ren_collide_set = 1'b0;
   logic        ren_maxspr_set = 1'b0;
   logic        attr_we;
   logic [8:0]  attr_addr;
   logic [7:0]  attr_wdata;
   logic        pat_we;
   logic [13:0] pat_addr;
   logic [7:0]  pat_wdata;

   int vectors = 0;
   int errors = 0;
   bit done = 1'b0;

   logic        c_awe, c_pwe;
   int          c_aaddr, c_paddr, c_adata, c_pdata;
   logic [7:0]  st;

   always #2.5 clk = ~clk;

   sprite_port_frontend i_sprite_port_frontend (
      .clk, .rst_n, .io_addr, .io_wdata, .io_wr, .io_rd, .io_rdata,
      .ren_collide_set, .ren_maxspr_set,
      .attr_we, .attr_addr, .attr_wdata, .pat_we, .pat_addr, .pat_wdata
   );

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic put(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      #1;
      c_awe = attr_we; c_aaddr = int'(attr_addr); c_adata = int'(attr_wdata);
      c_pwe = pat_we;  c_paddr = int'(pat_addr);  c_pdata = int'(pat_wdata);
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic get(input logic [15:0] a, output logic [7:0] v);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1;
      v = io_rdata;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic pulse(input logic c, input logic m);
      @(negedge clk);
      ren_collide_set = c; ren_maxspr_set = m;
      @(negedge clk);
      ren_collide_set = 1'b0; ren_maxspr_set = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R11 watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state
      #1;
      chk("R11 attr_we idle", int'(attr_we), 0);
      chk("R11 pat_we idle", int'(pat_we), 0);
      get(16'h303B, st);
      chk("R11 flags clear", int'(st), 0);
      put(16'h005B, 8'h11);
      chk("R11 pattern index zero", c_paddr, 0);
      put(16'h0057, 8'h22);
      chk("R11 attribute address zero", c_aaddr, 0);

      // R1..R6 sweep over every slot and both start offsets
      for (int s = 0; s < 64; s++) begin
         for (int h = 0; h < 2; h++) begin
            int len;
            int base;
            logic [7:0] d;
            len  = (s % 2 == 1) ? 5 : 4;
            base = s * 256 + h * 128;
            put(16'h303B, 8'(s + h * 128));
            chk("R1 select raises no strobe", int'(c_awe) + int'(c_pwe), 0);
            for (int b = 0; b < len; b++) begin
               if (b == 3) d = (len == 5) ? 8'h40 : 8'hBF;
               else        d = 8'h40 | 8'(b);
               put({8'(s + b), 8'h57}, d);
               chk("R4 attr_we", int'(c_awe), 1);
               chk("R4 attr_addr", c_aaddr, s * 8 + b);
               chk("R4 attr_wdata", c_adata, int'(d));
            end
            put(16'hA557, 8'h00);
            chk("R5 next record slot", c_aaddr, ((s + 1) % 64) * 8);
            for (int k = 0; k < 3; k++) begin
               put({8'(k * 7), 8'h5B}, 8'(s ^ k));
               chk("R3 pat_we", int'(c_pwe), 1);
               chk(k == 0 ? "R2 start offset (R6 attr did not move it)" : "R3 pat_addr",
                   c_paddr, base + k);
               chk("R3 pat_wdata", c_pdata, (s ^ k) & 255);
            end
         end
      end

      // R3: pattern index wrap from 16383 to 0
      put(16'h303B, 8'hBF);
      for (int k = 0; k < 128; k++) begin
         put(16'h005B, 8'(k));
         chk("R3 upper half of last slot", c_paddr, 16256 + k);
      end
      put(16'h005B, 8'hEE);
      chk("R3 wrap to zero", c_paddr, 0);
      put(16'h0057, 8'h01);
      chk("R6 pattern writes left attr index", c_aaddr, 63 * 8);

      // R10: select needs a full address match
      put(16'h303B, 8'h05);
      put(16'h313B, 8'h2A);
      chk("R10 partial select raises no strobe", int'(c_awe) + int'(c_pwe), 0);
      put(16'hFF57, 8'h00);
      chk("R10 attr index kept after partial select", c_aaddr, 5 * 8);
      put(16'h125B, 8'h00);
      chk("R10 pattern index kept after partial select", c_paddr, 5 * 256);

      // R7/R8: status read and clear
      pulse(1'b1, 1'b0);
      get(16'h303B, st);
      chk("R7 collision bit 0", int'(st), 1);
      get(16'h303B, st);
      chk("R8 cleared after read", int'(st), 0);
      pulse(1'b0, 1'b1);
      get(16'h303B, st);
      chk("R7 max-sprites bit 1", int'(st), 2);
      pulse(1'b1, 1'b1);
      pulse(1'b1, 1'b0);
      get(16'h303B, st);
      chk("R9 both flags sticky", int'(st), 3);
      get(16'h303B, st);
      chk("R8 both cleared", int'(st), 0);

      // R9: set during a clearing read wins
      pulse(1'b1, 1'b0);
      @(negedge clk);
      io_addr = 16'h303B; io_rd = 1'b1; ren_maxspr_set = 1'b1; ren_collide_set = 1'b1;
      #1;
      chk("R9 read in set cycle shows old flags", int'(io_rdata), 1);
      @(negedge clk);
      io_rd = 1'b0; ren_maxspr_set = 1'b0; ren_collide_set = 1'b0;
      get(16'h303B, st);
      chk("R9 set beats clear", int'(st), 3);
      get(16'h303B, st);
      chk("R8 clear after priority case", int'(st), 0);

      // R10: near-miss reads return 0 and clear nothing
      pulse(1'b1, 1'b0);
      get(16'h303A, st);
      chk("R10 read of 0x303A", int'(st), 0);
      get(16'h313B, st);
      chk("R10 read of 0x313B", int'(st), 0);
      get(16'h303B, st);
      chk("R10 flag survived near-miss reads", int'(st), 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule